// File: doc/BRIEF.md
# Amplifier Control Register Slave on a Two-Wire Bus

This block is the digital control port of a two-channel audio amplifier. It acts as a target on an I2C bus. SCL and SDA are sampled with the system clock, and SDA is pulled low through an open-drain enable. Its 7-bit bus address is `10000` followed by two strap bits. A master can read amplifier status and write the control, configuration and per-channel volume settings.

The first byte written after the address loads an 8-bit index. Its low seven bits point at a register, and its top bit chooses whether the pointer steps after each data byte. Later bytes in the same transfer, and bytes read after a repeated start, go to or come from the register the pointer selects. Protection and silence logic feed the status word. Two of its bits are sticky: an event sets them and writing 0 clears them. The other fields are live and read-only.

Top module: `amp_ctrl_i2c_slave`

## Requirements
- R1: The device address is `1,0,0,0,0,strap[1],strap[0]`, sent MSB first and followed by a direction bit (0 = master writes, 1 = master reads). On a match the slave pulls SDA low in the acknowledge slot. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Both are seen after two-flop synchronizers. The slave changes its SDA drive only while the synchronized SCL is low, and a stop releases SDA and returns the slave to idle.
- R3: The index resets to 0x00. In a write transfer, the first byte after the address loads the index.
- R4: When index bit 7 is 1, the pointer (index bits 6:0) increments after every data byte written or read, wrapping from 127 to 0.
- R5: When index bit 7 is 0, the index does not change on data bytes.
- R6: The read map is:
  - 0: status
  - 1: fault word `{4'b0, fault_flags}`
  - 2: speaker word `{2'b0, spk_missing[1:0], 4'b0}`
  - 3: `vol_adc`
  - 4: control `{mute, sleep, 3'b0, limit[2:0]}`
  - 5: configuration `{1'b0, cfg[6:0]}`
  - 6: volume channel 1
  - 7: volume channel 2
  
  Pointers 8 to 127 read 0x00 and ignore writes, and pointers 1 to 3 ignore writes.
- R7: The status word is `{ovl, ocur, 3'b000, silence, muted, fault}`. Bit 7 and bit 6 are set by `evt_overload` and `evt_overcurrent`. Writing 0 to one of them clears it, and writing 1 keeps it. Bits 2:0 are live inputs that writes do not change.
- R8: An event and a write of 0 to the same sticky bit in the same cycle leave the bit set.
- R9: After reset, mute and sleep are 0, the limit code is 000 (000 = 100%, 001 = 88%, 010 = 85%, 011 = 82%, 100 = 79%, 101 = 78%, 110 = 76%, 111 = 73%), configuration is 0, and both volumes are 0xFF (minimum).
- R10: During a read, a master ACK makes the slave send the next byte. A master NACK ends the transfer with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_strap | input | 2 | Low two bits of the device address |
| evt_overload | input | 1 | Sets the sticky overload bit |
| evt_overcurrent | input | 1 | Sets the sticky over-current bit |
| stat_silence | input | 1 | Live silence-mute flag |
| stat_muted | input | 1 | Live muted flag |
| stat_fault | input | 1 | Live fault summary |
| fault_flags | input | 4 | Live fault word, low nibble |
| spk_missing | input | 2 | Speaker-missing flags, channel 2 in bit 1 |
| vol_adc | input | 8 | Digitised volume knob value |
| ctl_mute | output | 1 | Mute request |
| ctl_sleep | output | 1 | Sleep request |
| ctl_limit | output | 3 | Input-limit code |
| cfg_bits | output | 7 | Configuration word |
| vol_ch1 | output | 8 | Channel 1 volume |
| vol_ch2 | output | 8 | Channel 2 volume |

## Verification
A hardware event and a bus write of 0 to the same sticky status bit can land in the same clock cycle. Without a rule, the clear would silently drop a fresh event. The bench provokes this by holding `evt_overcurrent` high for the whole status write, so the event is active in the commit cycle whatever the bus latency. It then reads the word back and expects bit 6 still set, while a later write with the event low must clear it.

// File: rtl/amp_i2c_pkg.sv
// Shared constants and types of the amplifier control slave.
// Assumes a 7-bit register pointer and an 8-register populated map.
package amp_i2c_pkg;
    localparam int BYTE_W  = 8;
    localparam int PTR_W   = 7;
    localparam int CNT_W   = 4;
    localparam logic [4:0] ADDR_FIXED = 5'b10000;

    localparam logic [PTR_W-1:0] P_STATUS = 7'd0;
    localparam logic [PTR_W-1:0] P_FAULT  = 7'd1;
    localparam logic [PTR_W-1:0] P_SPKR   = 7'd2;
    localparam logic [PTR_W-1:0] P_ADC    = 7'd3;
    localparam logic [PTR_W-1:0] P_CTRL   = 7'd4;
    localparam logic [PTR_W-1:0] P_CFG    = 7'd5;
    localparam logic [PTR_W-1:0] P_VOL1   = 7'd6;
    localparam logic [PTR_W-1:0] P_VOL2   = 7'd7;

    typedef enum logic [2:0] {
        BS_IDLE, BS_ADDR, BS_ADDR_ACK, BS_WR, BS_WR_ACK, BS_RD, BS_RD_ACK
    } bus_state_t;
endpackage

// File: rtl/amp_i2c_line_sync.sv
// Brings SCL and SDA into the clock domain through a flop chain per line,
// then derives SCL edges and start/stop conditions from the synchronized
// values. Assumes the bus is idle (both lines high) out of reset.
module amp_i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;
    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             scl_p, sda_p;

    assign raw = {scl_in, sda_in};

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            // Shift each line through its synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    // Keep one cycle of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/amp_i2c_bus_engine.sv
// Bit and byte sequencer of the bus target. Samples data on SCL rise and
// changes its SDA drive on SCL fall. Emits one-cycle strobes for an index
// load, a data write and the end of a read byte. Assumes no clock stretching.
module amp_i2c_bus_engine
    import amp_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              wr_idx_stb,
    output logic              wr_dat_stb,
    output logic              rd_adv_stb
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    bus_state_t        state_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              rw_q, first_q, nack_q;

    // Sequence bus phases and drive SDA
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= BS_IDLE;
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            rw_q       <= 1'b0;
            first_q    <= 1'b0;
            nack_q     <= 1'b0;
            sda_oe     <= 1'b0;
            wr_byte    <= '0;
            wr_idx_stb <= 1'b0;
            wr_dat_stb <= 1'b0;
            rd_adv_stb <= 1'b0;
        end else begin
            wr_idx_stb <= 1'b0;
            wr_dat_stb <= 1'b0;
            rd_adv_stb <= 1'b0;
            if (start_det) begin
                state_q   <= BS_ADDR;
                bit_cnt_q <= '0;
                sda_oe    <= 1'b0;
            end else if (stop_det) begin
                state_q <= BS_IDLE;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state_q)
                    BS_ADDR, BS_WR: begin
                        if (scl_rise && bit_cnt_q < FULL) begin
                            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (scl_fall && bit_cnt_q == FULL) begin
                            if (state_q == BS_ADDR) begin
                                if (shreg_q[7:1] == dev_addr) begin
                                    sda_oe  <= 1'b1;
                                    rw_q    <= shreg_q[0];
                                    state_q <= BS_ADDR_ACK;
                                end else begin
                                    state_q <= BS_IDLE;
                                end
                            end else begin
                                sda_oe     <= 1'b1;
                                wr_byte    <= shreg_q;
                                wr_idx_stb <= first_q;
                                wr_dat_stb <= ~first_q;
                                first_q    <= 1'b0;
                                state_q    <= BS_WR_ACK;
                            end
                        end
                    end
                    BS_ADDR_ACK: if (scl_fall) begin
                        bit_cnt_q <= '0;
                        if (rw_q) begin
                            shreg_q <= rd_byte;
                            sda_oe  <= ~rd_byte[BYTE_W-1];
                            state_q <= BS_RD;
                        end else begin
                            sda_oe  <= 1'b0;
                            first_q <= 1'b1;
                            state_q <= BS_WR;
                        end
                    end
                    BS_WR_ACK: if (scl_fall) begin
                        sda_oe    <= 1'b0;
                        bit_cnt_q <= '0;
                        state_q   <= BS_WR;
                    end
                    BS_RD: begin
                        if (scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (scl_fall && bit_cnt_q == FULL) begin
                            sda_oe     <= 1'b0;
                            rd_adv_stb <= 1'b1;
                            state_q    <= BS_RD_ACK;
                        end else if (scl_fall && bit_cnt_q != '0) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                            sda_oe  <= ~shreg_q[BYTE_W-2];
                        end
                    end
                    BS_RD_ACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_s;
                        end else if (scl_fall) begin
                            bit_cnt_q <= '0;
                            if (nack_q) begin
                                state_q <= BS_IDLE;
                            end else begin
                                shreg_q <= rd_byte;
                                sda_oe  <= ~rd_byte[BYTE_W-1];
                                state_q <= BS_RD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/amp_i2c_regfile.sv
// Index register, control and status storage, and read mux. Write and read
// strobes come from the bus engine; the pointer steps after a data byte
// only when the index top bit is set.
module amp_i2c_regfile
    import amp_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_idx_stb,
    input  logic              wr_dat_stb,
    input  logic              rd_adv_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              evt_overload,
    input  logic              evt_overcurrent,
    input  logic              stat_silence,
    input  logic              stat_muted,
    input  logic              stat_fault,
    input  logic [3:0]        fault_flags,
    input  logic [1:0]        spk_missing,
    input  logic [BYTE_W-1:0] vol_adc,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] idx_q,
    output logic [1:0]        sticky_q,
    output logic              ctl_mute,
    output logic              ctl_sleep,
    output logic [2:0]        ctl_limit,
    output logic [6:0]        cfg_bits,
    output logic [BYTE_W-1:0] vol_ch1,
    output logic [BYTE_W-1:0] vol_ch2
);
    logic [PTR_W-1:0] ptr;
    logic             wr_status;

    assign ptr       = idx_q[PTR_W-1:0];
    assign wr_status = wr_dat_stb && (ptr == P_STATUS);

    // Load the index or step the pointer after a data byte
    always_ff @(posedge clk) begin
        if (!rst_n)                                       idx_q <= '0;
        else if (wr_idx_stb)                              idx_q <= wr_byte;
        else if ((wr_dat_stb || rd_adv_stb) && idx_q[7]) idx_q[PTR_W-1:0] <= ptr + 1'b1;
    end

    // Sticky status bits: event has priority over a write of zero
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else sticky_q <= {evt_overload, evt_overcurrent}
                       | (sticky_q & ~({2{wr_status}} & ~wr_byte[7:6]));
    end

    // Writable control, configuration and volume registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_mute  <= 1'b0;
            ctl_sleep <= 1'b0;
            ctl_limit <= '0;
            cfg_bits  <= '0;
            vol_ch1   <= '1;
            vol_ch2   <= '1;
        end else if (wr_dat_stb) begin
            unique case (ptr)
                P_CTRL: begin
                    ctl_mute  <= wr_byte[7];
                    ctl_sleep <= wr_byte[6];
                    ctl_limit <= wr_byte[2:0];
                end
                P_CFG:   cfg_bits <= wr_byte[6:0];
                P_VOL1:  vol_ch1  <= wr_byte;
                P_VOL2:  vol_ch2  <= wr_byte;
                default: ;
            endcase
        end
    end

    // Select the byte returned for the current pointer
    always_comb begin
        unique case (ptr)
            P_STATUS: rd_byte = {sticky_q, 3'b000, stat_silence, stat_muted, stat_fault};
            P_FAULT:  rd_byte = {4'b0000, fault_flags};
            P_SPKR:   rd_byte = {2'b00, spk_missing, 4'b0000};
            P_ADC:    rd_byte = vol_adc;
            P_CTRL:   rd_byte = {ctl_mute, ctl_sleep, 3'b000, ctl_limit};
            P_CFG:    rd_byte = {1'b0, cfg_bits};
            P_VOL1:   rd_byte = vol_ch1;
            P_VOL2:   rd_byte = vol_ch2;
            default:  rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/amp_ctrl_i2c_slave.sv
// Top of the amplifier control slave: line synchronizer, bus engine and
// register file. Assumes SCL high and low phases last at least four clocks.
module amp_ctrl_i2c_slave
    import amp_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [1:0] addr_strap,
    input  logic       evt_overload,
    input  logic       evt_overcurrent,
    input  logic       stat_silence,
    input  logic       stat_muted,
    input  logic       stat_fault,
    input  logic [3:0] fault_flags,
    input  logic [1:0] spk_missing,
    input  logic [7:0] vol_adc,
    output logic       ctl_mute,
    output logic       ctl_sleep,
    output logic [2:0] ctl_limit,
    output logic [6:0] cfg_bits,
    output logic [7:0] vol_ch1,
    output logic [7:0] vol_ch2
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_idx_stb, wr_dat_stb, rd_adv_stb;
    logic [BYTE_W-1:0] wr_byte, rd_byte, idx_q;
    logic [1:0] sticky_q;

    amp_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    amp_i2c_bus_engine u_eng (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
        .dev_addr({ADDR_FIXED, addr_strap}), .rd_byte(rd_byte),
        .sda_oe(sda_oe), .wr_byte(wr_byte), .wr_idx_stb(wr_idx_stb),
        .wr_dat_stb(wr_dat_stb), .rd_adv_stb(rd_adv_stb)
    );

    amp_i2c_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_idx_stb(wr_idx_stb), .wr_dat_stb(wr_dat_stb),
        .rd_adv_stb(rd_adv_stb), .wr_byte(wr_byte), .evt_overload(evt_overload),
        .evt_overcurrent(evt_overcurrent), .stat_silence(stat_silence),
        .stat_muted(stat_muted), .stat_fault(stat_fault), .fault_flags(fault_flags),
        .spk_missing(spk_missing), .vol_adc(vol_adc), .rd_byte(rd_byte),
        .idx_q(idx_q), .sticky_q(sticky_q), .ctl_mute(ctl_mute),
        .ctl_sleep(ctl_sleep), .ctl_limit(ctl_limit), .cfg_bits(cfg_bits),
        .vol_ch1(vol_ch1), .vol_ch2(vol_ch2)
    );
endmodule

// File: rtl/amp_ctrl_i2c_checker.sv
// Protocol and register checks for amp_ctrl_i2c_slave, attached by bind.
module amp_ctrl_i2c_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       evt_overload,
    input logic       evt_overcurrent,
    input logic [1:0] sticky_q,
    input logic       wr_idx_stb,
    input logic       wr_dat_stb,
    input logic [7:0] wr_byte,
    input logic [7:0] idx_q,
    input logic       ctl_mute,
    input logic       ctl_sleep,
    input logic [2:0] ctl_limit,
    input logic [6:0] cfg_bits,
    input logic [7:0] vol_ch1,
    input logic [7:0] vol_ch2
);
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R2
    AST_EVENT_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_overload || evt_overcurrent) |=> ((sticky_q & $past({evt_overload, evt_overcurrent})) == $past({evt_overload, evt_overcurrent}))); // R8
    AST_ZERO_CLEARS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat_stb && idx_q[6:0] == 7'd0 && !wr_byte[7] && !evt_overload) |=> !sticky_q[1]); // R7
    AST_REGS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dat_stb |=> ($stable(ctl_mute) && $stable(ctl_sleep) && $stable(ctl_limit)
                         && $stable(cfg_bits) && $stable(vol_ch1) && $stable(vol_ch2))); // R6
    AST_INDEX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_idx_stb && !idx_q[7]) |=> $stable(idx_q)); // R5
    AST_INDEX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat_stb && idx_q[7]) |=> (idx_q[6:0] == 7'($past(idx_q[6:0]) + 7'd1))); // R4
endmodule

bind amp_ctrl_i2c_slave amp_ctrl_i2c_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .evt_overload(evt_overload), .evt_overcurrent(evt_overcurrent),
    .sticky_q(sticky_q), .wr_idx_stb(wr_idx_stb), .wr_dat_stb(wr_dat_stb),
    .wr_byte(wr_byte), .idx_q(idx_q), .ctl_mute(ctl_mute), .ctl_sleep(ctl_sleep),
    .ctl_limit(ctl_limit), .cfg_bits(cfg_bits), .vol_ch1(vol_ch1), .vol_ch2(vol_ch2)
);

// File: tb/amp_ctrl_i2c_slave_tb.sv
module amp_ctrl_i2c_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 10;
    localparam int NVEC = 9;
    localparam logic [7:0] AW = 8'h84;  // strap 2'b10, write
    localparam logic [7:0] AR = 8'h85;  // strap 2'b10, read
    // {pointer, written byte, expected read-back}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h04, 8'hC5, 8'hC5}, {8'h04, 8'hFF, 8'hC7}, {8'h05, 8'hA5, 8'h25},
        {8'h06, 8'h3C, 8'h3C}, {8'h07, 8'h00, 8'h00}, {8'h03, 8'h55, 8'h9A},
        {8'h01, 8'hFF, 8'h0A}, {8'h09, 8'hFF, 8'h00}, {8'h02, 8'hFF, 8'h20}};

    logic clk = 0, rst_n = 0, m_scl = 1, m_sda = 1;
    logic sda_oe, evt_ovl = 0, evt_oc = 0;
    logic ctl_mute, ctl_sleep;
    logic [2:0] ctl_limit;
    logic [6:0] cfg_bits;
    logic [7:0] vol_ch1, vol_ch2;
    wire sda_line = sda_oe ? 1'b0 : m_sda;
    int checks = 0, fails = 0;
    bit done = 0;
    logic ack;
    logic [7:0] rb;

    always #(CLK_PERIOD/2) clk = ~clk;

    amp_ctrl_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .addr_strap(2'b10), .evt_overload(evt_ovl), .evt_overcurrent(evt_oc),
        .stat_silence(1'b1), .stat_muted(1'b0), .stat_fault(1'b1),
        .fault_flags(4'hA), .spk_missing(2'b10), .vol_adc(8'h9A),
        .ctl_mute(ctl_mute), .ctl_sleep(ctl_sleep), .ctl_limit(ctl_limit),
        .cfg_bits(cfg_bits), .vol_ch1(vol_ch1), .vol_ch2(vol_ch2));

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1; hold(HALF); m_scl = 1; hold(HALF);
        m_sda = 0; hold(HALF); m_scl = 0; hold(2);
    endtask

    task automatic bus_stop();
        m_sda = 0; hold(HALF); m_scl = 1; hold(HALF); m_sda = 1; hold(HALF);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hold(HALF); m_scl = 1; hold(HALF); m_scl = 0; hold(2);
        end
        m_sda = 1; hold(HALF); m_scl = 1; hold(HALF/2);
        a = sda_line; hold(HALF/2); m_scl = 0; hold(2);
    endtask

    task automatic get_byte(input logic master_ack, output logic [7:0] d);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            hold(HALF); m_scl = 1; hold(HALF/2); d[i] = sda_line;
            hold(HALF/2); m_scl = 0; hold(2);
        end
        m_sda = master_ack; hold(HALF); m_scl = 1; hold(HALF); m_scl = 0; hold(2);
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
        logic a;
        bus_start(); put_byte(AW, a); put_byte(idx, a); put_byte(d, a); bus_stop();
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [7:0] d);
        logic a;
        bus_start(); put_byte(AW, a); put_byte(idx, a);
        bus_start(); put_byte(AR, a); get_byte(1'b1, d); bus_stop();
    endtask

    initial begin
        hold(150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_map [8];
        exp_map = '{8'h05, 8'h0A, 8'h20, 8'h9A, 8'h00, 8'h00, 8'hFF, 8'hFF};
        hold(5); rst_n = 1; hold(5);
        // R9: reset values at the ports
        chk("R9 mute/sleep/limit", {3'b0, ctl_mute, ctl_sleep, ctl_limit}, 8'h00);
        chk("R9 cfg", {1'b0, cfg_bits}, 8'h00);
        chk("R9 vol1", vol_ch1, 8'hFF);
        chk("R9 vol2", vol_ch2, 8'hFF);
        chk("R2 idle release", {7'b0, sda_oe}, 8'h00);

        // R1/R3/R4/R6/R10: auto-increment read of the whole map after reset
        bus_start(); put_byte(AW, ack);
        chk("R1 address ack", {7'b0, ack}, 8'h00);
        put_byte(8'h80, ack);
        chk("R3 index byte ack", {7'b0, ack}, 8'h00);
        bus_start(); put_byte(AR, ack);
        for (int i = 0; i < 8; i++) begin
            get_byte(i == 7, rb);
            chk("R4 R6 map read", rb, exp_map[i]);
        end
        chk("R10 released after NACK", {7'b0, sda_oe}, 8'h00);
        bus_stop();

        // R1: address with the wrong strap bits is not acknowledged
        bus_start(); put_byte(8'h86, ack); bus_stop();
        chk("R1 mismatch nack", {7'b0, ack}, 8'h01);

        // R6/R7: vector table of write then read-back
        for (int v = 0; v < NVEC; v++) begin
            wr_reg(VEC[v][23:16], VEC[v][15:8]);
            rd_reg(VEC[v][23:16], rb);
            chk("R6 vector", rb, VEC[v][7:0]);
        end
        chk("R6 control ports", {3'b0, ctl_mute, ctl_sleep, ctl_limit}, 8'h1F);

        // R5: index bit 7 clear keeps the pointer on one register
        bus_start(); put_byte(AW, ack); put_byte(8'h06, ack);
        put_byte(8'h11, ack); put_byte(8'h22, ack); bus_stop();
        chk("R5 vol1 last write", vol_ch1, 8'h22);
        chk("R5 vol2 untouched", vol_ch2, 8'h00);

        // R4: auto-increment burst write
        bus_start(); put_byte(AW, ack); put_byte(8'h84, ack);
        put_byte(8'h00, ack); put_byte(8'h01, ack); put_byte(8'h02, ack); put_byte(8'h03, ack);
        bus_stop();
        chk("R4 ctrl", {3'b0, ctl_mute, ctl_sleep, ctl_limit}, 8'h00);
        chk("R4 cfg", {1'b0, cfg_bits}, 8'h01);
        chk("R4 vol1", vol_ch1, 8'h02);
        chk("R4 vol2", vol_ch2, 8'h03);

        // R4: wrap 127 -> 0 -> 1, then current-pointer read
        bus_start(); put_byte(AW, ack); put_byte(8'hFF, ack);
        put_byte(8'hFF, ack); put_byte(8'hFF, ack); bus_stop();
        bus_start(); put_byte(AR, ack); get_byte(1'b1, rb); bus_stop();
        chk("R4 wrap pointer", rb, 8'h0A);

        // R7: sticky overload set by event, kept by 1, cleared by 0
        @(negedge clk); evt_ovl = 1; @(negedge clk); evt_ovl = 0;
        rd_reg(8'h00, rb);
        chk("R7 event sets bit7", rb, 8'h85);
        wr_reg(8'h00, 8'hFF); rd_reg(8'h00, rb);
        chk("R7 write one keeps", rb, 8'h85);
        wr_reg(8'h00, 8'h00); rd_reg(8'h00, rb);
        chk("R7 write zero clears", rb, 8'h05);

        // R8: event held across the clearing write wins
        @(negedge clk); evt_oc = 1;
        wr_reg(8'h00, 8'h00);
        @(negedge clk); evt_oc = 0;
        rd_reg(8'h00, rb);
        chk("R8 event beats clear", rb, 8'h45);
        wr_reg(8'h00, 8'h00); rd_reg(8'h00, rb);
        chk("R8 later clear", rb, 8'h05);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule